// File: doc/BRIEF.md
# Debug byte FIFO register bridge

This block sits on a 32-bit, word-aligned register bus. Behind it are two byte queues. The receive queue is filled by an external link and drained by the host. The transmit queue is filled by the host and drained by the external link. The host sees four word registers:

- a popping receive-data register;
- a non-popping mirror of that register one word higher;
- a write-only transmit-data register;
- a status/command register.

The mirror exists because the host bus prefetches the following word on every read. A prefetch that lands on the mirror reads the same byte but leaves the queue untouched. Software reads only the popping address.

Every access takes a one-cycle valid strobe and is accepted at once, because ready is held high. Read data is registered and is presented with a read-valid flag in the cycle after the accepted read. The external link uses plain push and pop ports with full and empty flags.

Top module: `dbg_byte_bridge`

## Requirements
- R1: After reset both queues are empty. `rx_full` is 0, `tx_empty` is 1, `bus_rvalid` is 0, and a status read returns 0x00000002.
- R2: A read at word offset 0x08 returns the oldest received byte in bits 7:0 with bits 31:8 zero, and removes that byte, so successive reads return the bytes in arrival order.
- R3: A read at offset 0x0C returns the same oldest byte as offset 0x08 but never removes it.
- R4: A read at 0x08 or 0x0C while the receive queue is empty returns 0x00000000 and changes no queue state, so a later byte still reads back correctly.
- R5: A write at offset 0x10 appends bits 7:0 of the write data to the transmit queue; bits 31:8 are ignored. The link pops the bytes from `tx_pop_data` in write order, and `tx_pop_data` shows the oldest byte without waiting for a pop.
- R6: Each queue holds 16 bytes. A write at 0x10 while the transmit queue holds 16 bytes is dropped.
- R7: Status (offset 0x14) reads bit 0 = receive queue not empty and bit 1 = transmit queue not full. All other bits read 0.
- R8: Writing status with bit 2 set empties the receive queue, and with bit 3 set empties the transmit queue, both in a single cycle. Both bits act only as commands and read back as 0.
- R9: `bus_ready` is always 1. `bus_rvalid` is 1 exactly in the cycle after each accepted read, and `bus_rdata` is valid in that cycle.
- R10: A link push while `rx_full` is 1 is dropped. A link pop while `tx_empty` is 1 has no effect.
- R11: Reads of the write-only register and of unmapped offsets (0x00, 0x04, 0x18, 0x1C) return 0. Writes to offsets other than 0x10 and 0x14 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted (held high) |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the accepted read |
| rx_push_valid | input | 1 | Link pushes a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue full |
| tx_pop | input | 1 | Link takes the head transmit byte |
| tx_pop_data | output | 8 | Head transmit byte (0 when empty) |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
The bench fills and drains both queues to exactly 16 entries over three rounds, so the pointers wrap. A design with a wrong full test would either overwrite the oldest byte or stop one entry early. Prefetch-style reads of the mirror are interleaved with popping reads. A mirror that advanced the pointer would make the next popping read skip a byte.

Empty-queue reads and pops are followed by a fresh push. If an empty read moved the pointer, the stale slot would surface in place of the new byte. The flush commands are issued while the other queue still holds data, which catches a flush that clears the wrong queue or both. Reads and writes of unmapped and read-only offsets are checked for zero data and for leaving the queue contents unchanged.

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned BYTE_W = 8;

   // register byte offsets; the peek alias must sit one word above the pop register
   localparam logic [7:0] OFS_RX_POP  = 8'h08;
   localparam logic [7:0] OFS_RX_PEEK = 8'h0C;
   localparam logic [7:0] OFS_TX_PUSH = 8'h10;
   localparam logic [7:0] OFS_STATUS  = 8'h14;

   // status bit positions
   localparam int unsigned ST_RX_AVAIL = 0;
   localparam int unsigned ST_TX_ROOM  = 1;
   localparam int unsigned ST_RX_FLUSH = 2;
   localparam int unsigned ST_TX_FLUSH = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RX_POP,
      SEL_RX_PEEK,
      SEL_TX_PUSH,
      SEL_STATUS
   } reg_sel_e;

endpackage

// File: rtl/dbgb_regdec.sv
module dbgb_regdec
   import dbgb_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-3:0] word_idx,
   output reg_sel_e          sel
);

   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam logic [IDX_W-1:0] IDX_RX_POP  = IDX_W'(OFS_RX_POP  >> 2);
   localparam logic [IDX_W-1:0] IDX_RX_PEEK = IDX_W'(OFS_RX_PEEK >> 2);
   localparam logic [IDX_W-1:0] IDX_TX_PUSH = IDX_W'(OFS_TX_PUSH >> 2);
   localparam logic [IDX_W-1:0] IDX_STATUS  = IDX_W'(OFS_STATUS  >> 2);

   always_comb begin
      sel = SEL_NONE;
      if (word_idx == IDX_RX_POP)       sel = SEL_RX_POP;
      else if (word_idx == IDX_RX_PEEK) sel = SEL_RX_PEEK;
      else if (word_idx == IDX_TX_PUSH) sel = SEL_TX_PUSH;
      else if (word_idx == IDX_STATUS)  sel = SEL_STATUS;
   end

endmodule

// File: rtl/dbgb_fifo.sv
module dbgb_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [DATA_W-1:0]          push_data,
   input  logic                       pop,
   output logic [DATA_W-1:0]          head,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH):0]     level
);

   localparam int unsigned PTR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("dbgb_fifo: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dbgb_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W:0]    wr_ptr;
   logic [PTR_W:0]    rd_ptr;
   logic              push_ok;
   logic              pop_ok;

   assign empty = (wr_ptr == rd_ptr);
   assign full  = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                  (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
   assign level = wr_ptr - rd_ptr;

   // flush has priority over both push and pop in the same cycle
   assign push_ok = push && !full  && !flush;
   assign pop_ok  = pop  && !empty && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) store[wr_ptr[PTR_W-1:0]] <= push_data;
   end

   assign head = store[rd_ptr[PTR_W-1:0]];

endmodule

// File: rtl/dbgb_rsp.sv
module dbgb_rsp
   import dbgb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  reg_sel_e          sel,
   input  logic [BYTE_W-1:0] rx_head,
   input  logic              rx_empty,
   input  logic              tx_full,
   output logic [WORD_W-1:0] rdata,
   output logic              rvalid
);

   logic [WORD_W-1:0] word;

   always_comb begin
      word = '0;
      case (sel)
         SEL_RX_POP, SEL_RX_PEEK: begin
            if (!rx_empty) word[BYTE_W-1:0] = rx_head;
         end
         SEL_STATUS: begin
            word[ST_RX_AVAIL] = !rx_empty;
            word[ST_TX_ROOM]  = !tx_full;
         end
         default: word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd;
         if (rd) rdata <= word;
      end
   end

endmodule

// File: rtl/dbg_byte_bridge.sv
module dbg_byte_bridge
   import dbgb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned TX_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_ready,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   input  logic              rx_push_valid,
   input  logic [7:0]        rx_push_data,
   output logic              rx_full,
   input  logic              tx_pop,
   output logic [7:0]        tx_pop_data,
   output logic              tx_empty
);

   localparam int unsigned RX_LW = $clog2(RX_DEPTH) + 1;
   localparam int unsigned TX_LW = $clog2(TX_DEPTH) + 1;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("dbg_byte_bridge: ADDR_W must cover offset 0x14");
      end
   endgenerate

   reg_sel_e          sel;
   logic              acc_rd;
   logic              acc_wr;
   logic              rx_pop;
   logic              rx_flush;
   logic              tx_push;
   logic              tx_flush;
   logic [BYTE_W-1:0] rx_head;
   logic [BYTE_W-1:0] tx_head;
   logic              rx_empty;
   logic              tx_full;
   logic [RX_LW-1:0]  rx_level;
   logic [TX_LW-1:0]  tx_level;
   logic              unused_bits;

   assign bus_ready   = 1'b1;
   assign acc_rd      = bus_valid && bus_ready && !bus_write;
   assign acc_wr      = bus_valid && bus_ready &&  bus_write;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8]};

   dbgb_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .word_idx (bus_addr[ADDR_W-1:2]),
      .sel      (sel)
   );

   assign rx_pop   = acc_rd && (sel == SEL_RX_POP);
   assign tx_push  = acc_wr && (sel == SEL_TX_PUSH);
   assign rx_flush = acc_wr && (sel == SEL_STATUS) && bus_wdata[ST_RX_FLUSH];
   assign tx_flush = acc_wr && (sel == SEL_STATUS) && bus_wdata[ST_TX_FLUSH];

   dbgb_fifo #(.DATA_W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .push      (rx_push_valid),
      .push_data (rx_push_data),
      .pop       (rx_pop),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full),
      .level     (rx_level)
   );

   dbgb_fifo #(.DATA_W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .push      (tx_push),
      .push_data (bus_wdata[BYTE_W-1:0]),
      .pop       (tx_pop),
      .head      (tx_head),
      .empty     (tx_empty),
      .full      (tx_full),
      .level     (tx_level)
   );

   assign tx_pop_data = tx_empty ? '0 : tx_head;

   dbgb_rsp u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (acc_rd),
      .sel      (sel),
      .rx_head  (rx_head),
      .rx_empty (rx_empty),
      .tx_full  (tx_full),
      .rdata    (bus_rdata),
      .rvalid   (bus_rvalid)
   );

endmodule

// File: rtl/dbgb_checker.sv
module dbgb_checker #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned TX_DEPTH = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_valid,
   input logic                        bus_write,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [31:0]                 bus_wdata,
   input logic                        bus_rvalid,
   input logic [31:0]                 bus_rdata,
   input logic                        rx_push_valid,
   input logic                        rx_full,
   input logic                        tx_pop,
   input logic [$clog2(RX_DEPTH):0]   rx_level,
   input logic [$clog2(TX_DEPTH):0]   tx_level
);

   localparam int unsigned RX_LW = $clog2(RX_DEPTH) + 1;
   localparam int unsigned TX_LW = $clog2(TX_DEPTH) + 1;
   localparam int unsigned IW    = ADDR_W - 2;
   localparam logic [RX_LW-1:0] RX_MAX = RX_LW'(RX_DEPTH);
   localparam logic [TX_LW-1:0] TX_MAX = TX_LW'(TX_DEPTH);

   logic [IW-1:0] w;
   logic rd, wr;
   assign w  = bus_addr[ADDR_W-1:2];
   assign rd = bus_valid && !bus_write;
   assign wr = bus_valid &&  bus_write;

   // R9: every read answers in the next cycle, nothing else does
   a_r9_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> bus_rvalid);
   a_r9_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !bus_rvalid);
   // R7: upper bits of any read word are zero
   a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> (bus_rdata[31:8] == 24'h0));
   // R4: popping read of an empty queue returns zero
   a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && w == IW'(2) && rx_level == '0) |=> (bus_rdata == 32'h0));
   // R3: peek alias never lowers the receive level
   a_r3_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && w == IW'(3) && !rx_push_valid) |=> (rx_level == $past(rx_level)));
   // R2: popping read of a non-empty queue removes exactly one byte
   a_r2_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && w == IW'(2) && rx_level != '0 && !rx_push_valid)
      |=> (rx_level == RX_LW'($past(rx_level) - 1'b1)));
   // R6: full transmit queue drops a write
   a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && w == IW'(4) && tx_level == TX_MAX && !tx_pop) |=> (tx_level == TX_MAX));
   // R8: flush commands empty their queue in one cycle
   a_r8_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && w == IW'(5) && bus_wdata[2]) |=> (rx_level == '0));
   a_r8_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && w == IW'(5) && bus_wdata[3]) |=> (tx_level == '0));
   // R10: levels never exceed depth; a push into a full queue is dropped
   a_r10_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level <= RX_MAX) && (tx_level <= TX_MAX));
   a_r10_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push_valid && rx_full && !(rd && w == IW'(2)) && !(wr && w == IW'(5)))
      |=> rx_full);

endmodule

bind dbg_byte_bridge dbgb_checker #(
   .ADDR_W   (ADDR_W),
   .RX_DEPTH (RX_DEPTH),
   .TX_DEPTH (TX_DEPTH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_valid     (bus_valid),
   .bus_write     (bus_write),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .bus_rvalid    (bus_rvalid),
   .bus_rdata     (bus_rdata),
   .rx_push_valid (rx_push_valid),
   .rx_full       (rx_full),
   .tx_pop        (tx_pop),
   .rx_level      (rx_level),
   .tx_level      (tx_level)
);

// File: tb/dbg_byte_bridge_test.sv
module dbg_byte_bridge_test;

   localparam int CLK_P = 10;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        rx_push_valid = 1'b0;
   logic [7:0]  rx_push_data = '0;
   logic        rx_full;
   logic        tx_pop = 1'b0;
   logic [7:0]  tx_pop_data;
   logic        tx_empty;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dbg_byte_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid),
      .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data), .rx_full(rx_full),
      .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_empty(tx_empty)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata; v = bus_rvalid;
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic link_push(input logic [7:0] b);
      @(negedge clk);
      rx_push_valid = 1'b1; rx_push_data = b;
      @(negedge clk);
      rx_push_valid = 1'b0;
   endtask

   task automatic link_pop(output logic [7:0] b, output logic e);
      @(negedge clk);
      b = tx_pop_data; e = tx_empty; tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed + i * 37) & 255);
   endfunction

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        v;
      logic [7:0]  b;
      logic        e;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rx_full", {31'd0, rx_full}, 32'd0);
      check("R1 tx_empty", {31'd0, tx_empty}, 32'd1);
      check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
      check("R9 ready", {31'd0, bus_ready}, 32'd1);
      bus_rd(8'h14, d, v);
      check("R1 status", d, 32'h2);
      check("R9 rvalid after read", {31'd0, v}, 32'd1);
      @(negedge clk);
      check("R9 rvalid drops", {31'd0, bus_rvalid}, 32'd0);

      for (int r = 0; r < 3; r++) begin
         int seed;
         seed = r * 53 + 11;
         for (int i = 0; i < DEPTH; i++) link_push(pat(seed, i));
         check("R10 rx_full", {31'd0, rx_full}, 32'd1);
         link_push(8'hEE);                       // R10 dropped
         bus_rd(8'h14, d, v);
         check("R7 status rx avail", d, 32'h3);
         bus_rd(8'h0C, d, v);
         check("R3 peek", d, {24'd0, pat(seed, 0)});
         bus_rd(8'h0C, d, v);
         check("R3 peek again", d, {24'd0, pat(seed, 0)});
         for (int i = 0; i < DEPTH; i++) begin
            bus_rd(8'h08, d, v);
            check("R2 pop order", d, {24'd0, pat(seed, i)});
            if (i == 7) begin
               bus_rd(8'h0C, d, v);
               check("R3 peek mid", d, {24'd0, pat(seed, 8)});
            end
         end
         bus_rd(8'h08, d, v);
         check("R4 empty pop", d, 32'h0);
         bus_rd(8'h0C, d, v);
         check("R4 empty peek", d, 32'h0);
         bus_rd(8'h14, d, v);
         check("R7 status empty", d, 32'h2);

         for (int i = 0; i < DEPTH; i++)
            bus_wr(8'h10, {8'hA5, 8'(r), 8'h5A, pat(seed, i) ^ 8'hFF});
         bus_wr(8'h10, 32'h0000003C);            // R6 dropped
         bus_rd(8'h14, d, v);
         check("R6 status tx full", d, 32'h0);
         for (int i = 0; i < DEPTH; i++) begin
            link_pop(b, e);
            check("R5 tx order", {24'd0, b}, {24'd0, pat(seed, i) ^ 8'hFF});
         end
         check("R6 extra dropped", {31'd0, tx_empty}, 32'd1);
      end

      // R10 pop on empty, then one write
      link_pop(b, e);
      check("R10 empty pop flag", {31'd0, e}, 32'd1);
      check("R10 still empty", {31'd0, tx_empty}, 32'd1);
      bus_wr(8'h10, 32'h00000077);
      link_pop(b, e);
      check("R5 after empty pop", {24'd0, b}, 32'h77);

      // R4 empty reads leave pointer in place
      bus_rd(8'h08, d, v);
      bus_rd(8'h08, d, v);
      link_push(8'h5A);
      bus_rd(8'h08, d, v);
      check("R4 pointer kept", d, 32'h5A);

      // R8 flushes
      for (int i = 0; i < 5; i++) begin
         link_push(8'(i + 1));
         bus_wr(8'h10, 32'(i + 100));
      end
      bus_wr(8'h14, 32'h4);
      bus_rd(8'h14, d, v);
      check("R8 rx flushed, flush bit reads 0", d, 32'h2);
      check("R8 tx kept", {31'd0, tx_empty}, 32'd0);
      bus_rd(8'h08, d, v);
      check("R8 rx empty read", d, 32'h0);
      link_push(8'hC3);
      bus_rd(8'h0C, d, v);
      check("R8 rx after flush", d, 32'hC3);
      bus_wr(8'h14, 32'h8);
      check("R8 tx flushed", {31'd0, tx_empty}, 32'd1);
      bus_rd(8'h14, d, v);
      check("R8 status rx kept", d, 32'h3);
      bus_wr(8'h14, 32'hC);
      bus_rd(8'h14, d, v);
      check("R8 both flushed", d, 32'h2);

      // R11 unmapped and read-only offsets
      link_push(8'h9D);
      bus_rd(8'h00, d, v); check("R11 read 0x00", d, 32'h0);
      bus_rd(8'h04, d, v); check("R11 read 0x04", d, 32'h0);
      bus_rd(8'h10, d, v); check("R11 read 0x10", d, 32'h0);
      bus_rd(8'h18, d, v); check("R11 read 0x18", d, 32'h0);
      bus_rd(8'h1C, d, v); check("R11 read 0x1C", d, 32'h0);
      bus_wr(8'h08, 32'h000000FF);
      bus_wr(8'h0C, 32'h000000FF);
      bus_wr(8'h00, 32'h0000000C);
      bus_wr(8'h18, 32'h0000000C);
      check("R11 tx untouched", {31'd0, tx_empty}, 32'd1);
      bus_rd(8'h08, d, v);
      check("R11 rx untouched", d, 32'h9D);
      bus_rd(8'h14, d, v);
      check("R11 status after", d, 32'h2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule